// File: doc/BRIEF.md
# Sleep Interval and Watchdog Timer

This block turns a slow timebase enable, nominally 512 pulses per second, into a periodic wake-up strobe. A two-bit interval select in a write-only control byte chooses how many timebase pulses make one interval: 1, 8, 64 or 512. The nominal results are shown below.

| Select | Wake rate | Wake period | Watchdog period |
|--------|-----------|-------------|-----------------|
| 00 | 512 Hz | about 2 ms | about 6 ms |
| 01 | 64 Hz | about 16 ms | about 47 ms |
| 10 | 8 Hz | 125 ms | 375 ms |
| 11 | 1 Hz | 1 s | 3 s |

The same wake strobe drives a watchdog. The watchdog issues a reset pulse after three wake strobes in a row with no clear from software between them. That makes the watchdog period three wake periods for every select.

The block also produces the enable for an external supply-voltage monitor. Outside sleep the enable stays high. During sleep it copies a duty-cycle strobe that runs independently of the interval select. When the control byte's override bit is set, the enable instead stays high for the whole of sleep. This trades a little sleep current for faster detection of supply faults.

Top module: `sleep_wdt_timer`

## Requirements
- R1: After a synchronous reset, `cfg_rdata_o` is 0x00, `wake_pulse_o` and `wdt_reset_o` are low, and `mon_en_o` is high.
- R2: A write stores bits [4:3] of `cfg_wdata_i` as the interval select and bit 5 as the monitor override. `cfg_rdata_o` returns these bits in the same positions from the cycle after the write. Bits [7:6] and [2:0] always read 0.
- R3: With select 00, 01, 10 or 11, `wake_pulse_o` goes high for exactly one cycle in the clock cycle after every 1st, 8th, 64th or 512th counted `base_tick_i` pulse, respectively.
- R4: Any write to the control byte restarts the interval count from zero. A tick in the same cycle as a write is not counted, so the next wake pulse needs a full interval of ticks after the write.
- R5: When the third wake pulse arrives with no `wdt_clear_i` since the watchdog count last restarted, `wdt_reset_o` goes high for one cycle in the cycle after that wake pulse. The count then starts again from zero.
- R6: `wdt_clear_i` resets the watchdog count to zero. A clear in the same cycle that a wake pulse is visible wins, and that wake pulse is not counted.
- R7: While `sleep_i` is low, `mon_en_o` is high in the following cycle.
- R8: While `sleep_i` is high and the override bit is 0, `mon_en_o` equals the previous cycle's `duty_strobe_i`, for any interval select.
- R9: While `sleep_i` is high and the override bit is 1, `mon_en_o` is high in the following cycle, whatever `duty_strobe_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte readback |
| base_tick_i | input | 1 | Single-cycle slow timebase enable |
| sleep_i | input | 1 | High while the system sleeps |
| wdt_clear_i | input | 1 | Watchdog clear from software |
| duty_strobe_i | input | 1 | Monitor duty-cycle strobe |
| wake_pulse_o | output | 1 | One-cycle interval expiry pulse |
| wdt_reset_o | output | 1 | One-cycle watchdog expiry pulse |
| mon_en_o | output | 1 | Supply monitor enable |

## Verification
The hardest case to reach is the full 512-tick interval of select 11, together with the watchdog expiring exactly on its third wake pulse. The bench holds the tick high on every clock for more than a thousand cycles so that several long intervals and one watchdog expiry occur.

The other hard case is the race between a clear and a wake pulse. The clear is timed relative to the sparse tick pattern so that it arrives exactly in the cycle where the watchdog sees the wake pulse. A separate test places a write on the same clock as a tick, which shows that the tick is discarded.

// File: rtl/swt_pkg.sv
package swt_pkg;
  // Width of the interval select field
  parameter int unsigned SWT_SEL_W = 2;
  // Field positions inside the control byte
  parameter int unsigned SEL_LSB = 3;
  parameter int unsigned OVR_BIT = 5;

  typedef struct packed {
    logic                 ovr;
    logic [SWT_SEL_W-1:0] sel;
  } swt_cfg_t;
endpackage

// File: rtl/swt_cfg_reg.sv
module swt_cfg_reg
  import swt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output swt_cfg_t   cfg_o,
  output logic [7:0] rdata_o
);
  logic unused_bits;
  assign unused_bits = ^{wdata_i[7:6], wdata_i[2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else if (wr_i) begin
      cfg_o.sel <= wdata_i[SEL_LSB +: SWT_SEL_W];
      cfg_o.ovr <= wdata_i[OVR_BIT];
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[SEL_LSB +: SWT_SEL_W] = cfg_o.sel;
    rdata_o[OVR_BIT] = cfg_o.ovr;
  end

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_i)) |->
      (cfg_o.sel == $past(wdata_i[SEL_LSB +: SWT_SEL_W]) && cfg_o.ovr == $past(wdata_i[OVR_BIT])));
endmodule

// File: rtl/swt_interval.sv
module swt_interval #(
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             wake_o
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned CNT_W = STEP_LOG2 * (NSEL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  // Terminal count for each select: 2^(STEP_LOG2*sel) - 1
  always_comb begin
    last_c = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (sel_i == SEL_W'(i)) last_c = CNT_W'((64'd1 << (STEP_LOG2 * i)) - 64'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wake_o <= 1'b0;
    end else begin
      wake_o <= 1'b0;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (cnt_q == last_c) begin
          cnt_q  <= '0;
          wake_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R3
  wake_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wake_o) |-> ($past(tick_i) && !$past(restart_i)));
  // R4
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restart_i)) |-> (cnt_q == '0 && !wake_o));
  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_c);
endmodule

// File: rtl/swt_watchdog.sv
module swt_watchdog #(
  parameter int unsigned EXPIRES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic wake_i,
  output logic bite_o
);
  localparam int unsigned EC_W = $clog2(EXPIRES + 1);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(EXPIRES - 1);

  logic [EC_W-1:0] ec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ec_q   <= '0;
      bite_o <= 1'b0;
    end else begin
      bite_o <= 1'b0;
      if (clear_i) begin
        ec_q <= '0;
      end else if (wake_i) begin
        if (ec_q == EC_LAST) begin
          ec_q   <= '0;
          bite_o <= 1'b1;
        end else begin
          ec_q <= ec_q + 1'b1;
        end
      end
    end
  end

  // R5
  bite_after_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && bite_o) |-> ($past(wake_i) && !$past(clear_i)));
  // R6
  clear_resets_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clear_i)) |-> (ec_q == '0 && !bite_o));
  // R5
  ec_range_chk: assert property (@(posedge clk) disable iff (rst)
    ec_q <= EC_LAST);
endmodule

// File: rtl/swt_mon_gate.sv
module swt_mon_gate (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  input  logic ovr_i,
  input  logic duty_i,
  output logic mon_en_o
);
  always_ff @(posedge clk) begin
    if (rst) mon_en_o <= 1'b1;
    else     mon_en_o <= !sleep_i || ovr_i || duty_i;
  end

  // R7
  awake_mon_on_chk: assert property (@(posedge clk) disable iff (rst)
    !sleep_i |=> mon_en_o);
  // R9
  override_mon_on_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && ovr_i) |=> mon_en_o);
  // R8
  duty_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !ovr_i) |=> (mon_en_o == $past(duty_i)));
endmodule

// File: rtl/sleep_wdt_timer.sv
module sleep_wdt_timer
  import swt_pkg::*;
#(
  parameter int unsigned STEP_LOG2   = 3,
  parameter int unsigned WDT_EXPIRES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  input  logic       base_tick_i,
  input  logic       sleep_i,
  input  logic       wdt_clear_i,
  input  logic       duty_strobe_i,
  output logic       wake_pulse_o,
  output logic       wdt_reset_o,
  output logic       mon_en_o
);
  swt_cfg_t cfg;

  swt_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_rdata_o)
  );

  swt_interval #(
    .SEL_W     (SWT_SEL_W),
    .STEP_LOG2 (STEP_LOG2)
  ) u_interval (
    .clk       (clk),
    .rst       (rst),
    .restart_i (cfg_wr_i),
    .tick_i    (base_tick_i),
    .sel_i     (cfg.sel),
    .wake_o    (wake_pulse_o)
  );

  swt_watchdog #(
    .EXPIRES (WDT_EXPIRES)
  ) u_wdt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (wdt_clear_i),
    .wake_i  (wake_pulse_o),
    .bite_o  (wdt_reset_o)
  );

  swt_mon_gate u_mon (
    .clk      (clk),
    .rst      (rst),
    .sleep_i  (sleep_i),
    .ovr_i    (cfg.ovr),
    .duty_i   (duty_strobe_i),
    .mon_en_o (mon_en_o)
  );
endmodule

// File: tb/tb_sleep_wdt_timer.sv
module tb_sleep_wdt_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       base_tick_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic       wdt_clear_i = 1'b0;
  logic       duty_strobe_i = 1'b0;
  logic       wake_pulse_o, wdt_reset_o, mon_en_o;

  always #10 clk = ~clk;

  sleep_wdt_timer dut (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr_i      (cfg_wr_i),
    .cfg_wdata_i   (cfg_wdata_i),
    .cfg_rdata_o   (cfg_rdata_o),
    .base_tick_i   (base_tick_i),
    .sleep_i       (sleep_i),
    .wdt_clear_i   (wdt_clear_i),
    .duty_strobe_i (duty_strobe_i),
    .wake_pulse_o  (wake_pulse_o),
    .wdt_reset_o   (wdt_reset_o),
    .mon_en_o      (mon_en_o)
  );

  typedef struct {
    logic       wake;
    logic       wdt;
    logic       mon;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state, built from the requirements
  logic [1:0] m_sel = 2'b00;
  logic       m_ovr = 1'b0;
  int         m_cnt = 0;
  int         m_ec = 0;
  logic       m_prev_wake = 1'b0;

  function automatic int ratio(input logic [1:0] s);
    return 1 << (3 * int'(s));
  endfunction

  task automatic step(input logic wr, input logic [7:0] d, input logic tk,
                      input logic sl, input logic cl, input logic du, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr_i = wr; cfg_wdata_i = d; base_tick_i = tk;
    sleep_i = sl; wdt_clear_i = cl; duty_strobe_i = du;
    e.tag  = tag;
    e.wake = !wr && tk && (m_cnt == ratio(m_sel) - 1);
    if (wr) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt == ratio(m_sel) - 1) ? 0 : m_cnt + 1;
    e.wdt = 1'b0;
    if (cl) m_ec = 0;
    else if (m_prev_wake) begin
      if (m_ec == 2) begin e.wdt = 1'b1; m_ec = 0; end
      else m_ec++;
    end
    m_prev_wake = e.wake;
    e.mon = !sl || m_ovr || du;
    if (wr) begin m_sel = d[4:3]; m_ovr = d[5]; end
    e.rd = {2'b00, m_ovr, m_sel, 3'b000};
    q.push_back(e);
  endtask

  // Scoreboard monitor: compares each queued item after its clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 0;
        vectors++;
        if (wake_pulse_o !== e.wake) begin
          bad = 1;
          $display("FAIL %s wake_pulse_o got %0b exp %0b", e.tag, wake_pulse_o, e.wake);
        end
        if (wdt_reset_o !== e.wdt) begin
          bad = 1;
          $display("FAIL %s wdt_reset_o got %0b exp %0b", e.tag, wdt_reset_o, e.wdt);
        end
        if (mon_en_o !== e.mon) begin
          bad = 1;
          $display("FAIL %s mon_en_o got %0b exp %0b", e.tag, mon_en_o, e.mon);
        end
        if (cfg_rdata_o !== e.rd) begin
          bad = 1;
          $display("FAIL %s cfg_rdata_o got %02h exp %02h", e.tag, cfg_rdata_o, e.rd);
        end
        if (bad) miscompares++;
      end
    end
  end

  // Watchdog on the run itself
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL run timeout got hung exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, before any edge out of reset
    vectors++;
    if (cfg_rdata_o !== 8'h00 || wake_pulse_o !== 1'b0 || wdt_reset_o !== 1'b0 || mon_en_o !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 outputs got %02h/%0b/%0b/%0b exp 00/0/0/1",
               cfg_rdata_o, wake_pulse_o, wdt_reset_o, mon_en_o);
    end

    // R2: field placement and reserved bits
    step(1, 8'hFF, 0, 0, 0, 0, "R2");
    step(0, 8'h00, 0, 0, 0, 0, "R2");
    step(1, 8'hC7, 0, 0, 0, 0, "R2");
    step(1, 8'h28, 0, 0, 0, 0, "R2");
    step(1, 8'h00, 0, 0, 1, 0, "R2");

    // R3: select 00, dense then sparse ticks
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 0, 0, "R3");
    for (int i = 0; i < 12; i++) step(0, 0, 1'(i % 2), 0, 0, 0, "R3");
    // R3: select 01, tick every third cycle
    step(1, 8'h08, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 60; i++) step(0, 0, 1'(i % 3 == 0), 0, 0, 0, "R3");
    // R3: select 10
    step(1, 8'h10, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 200; i++) step(0, 0, 1, 0, 0, 0, "R3");
    // R3/R5: select 11, long interval with a watchdog expiry
    step(1, 8'h18, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 1600; i++) step(0, 0, 1, 0, 0, 0, "R5");

    // R4: write mid-count and a write together with a tick
    step(1, 8'h08, 0, 0, 1, 0, "R4");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0, 0, "R4");
    step(1, 8'h08, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, 0, "R4");
    step(1, 8'h00, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, "R4");

    // R5: select 00, sparse ticks and no clear
    step(0, 0, 0, 0, 1, 0, "R5");
    for (int i = 0; i < 40; i++) step(0, 0, 1'(i % 4 == 0), 0, 0, 0, "R5");

    // R6: clear lands in the cycle the wake pulse is visible
    step(0, 0, 0, 0, 1, 0, "R6");
    for (int i = 0; i < 64; i++) step(0, 0, 1'(i % 4 == 0), 0, 1'(i % 8 == 1), 0, "R6");
    for (int i = 0; i < 48; i++) step(0, 0, 1'(i % 4 == 0), 0, 1'(i % 12 == 2), 0, "R6");

    // R7: awake, strobe toggling, override clear
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 1, 1'($urandom_range(0, 1)), "R7");

    // R8: asleep, override clear, two selects
    for (int i = 0; i < 24; i++) step(0, 0, 0, 1, 1, 1'($urandom_range(0, 1)), "R8");
    step(1, 8'h18, 0, 1, 1, 0, "R8");
    for (int i = 0; i < 24; i++) step(0, 0, 0, 1, 1, 1'($urandom_range(0, 1)), "R8");

    // R9: override set, strobe low or toggling, sleep toggling
    step(1, 8'h20, 0, 1, 1, 0, "R9");
    for (int i = 0; i < 24; i++) step(0, 0, 0, 1, 1, 1'($urandom_range(0, 1)), "R9");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1'(i % 3 != 0), 1, 0, "R9");
    step(1, 8'h00, 0, 1, 1, 0, "R8");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, 1'(i % 2), "R8");

    step(0, 0, 0, 0, 0, 0, "R7");
    wait (q.size() == 0);
    @(posedge clk);
    #3;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule